// File: doc/BRIEF.md
# Software Reset Line Controller

This block drives a bank of active-low reset lines into peripheral and core domains. Software reaches it through a small write/read register port. Each write carries a line mask, and the register address picks what happens to the selected lines:

- **Hold:** the line is put into reset and stays there.
- **Free:** the line is let go.
- **Pulse:** the line goes into reset and comes out again by itself after a fixed number of clock cycles. A busy flag shows that the timer is running.

Each line also carries two override bits, one per low-power state. While the low-power request input is valid, the bit for the requested state sets the line level in place of the run-mode value. In that bit, 0 puts the line in reset and 1 lets it go. A status read returns the level each line is driving right now.

Top module: `rst_line_ctrl`

## Requirements
- R1: During and after synchronous reset, every line output is 0 (in reset), every busy bit is 0, and both override registers read 0.
- R2: A write to address 0 puts each line whose mask bit is 1 into reset. The line stays there with no timeout until a free or pulse command reaches it. Lines whose mask bit is 0 keep their state.
- R3: A write to address 1 frees each line whose mask bit is 1. Lines whose mask bit is 0 keep their state.
- R4: A write to address 2 starts a pulse on each masked line. The line output is 0 for exactly PULSE_CYCLES clock cycles, starting with the edge that takes the write, and then returns to 1 with no further write.
- R5: Reading address 1 returns the busy bits. A line's busy bit is 1 while its pulse timer runs and 0 otherwise.
- R6: A pulse written to a line that is already held in reset keeps it in reset. The hold time restarts from that write, and the line is freed PULSE_CYCLES cycles later.
- R7: A free written during a pulse releases the line at once and clears its busy bit. A hold written during a pulse stops the timer, clears busy and keeps the line in reset indefinitely.
- R8: While lp_valid is 1, each line drives its override bit for the state selected by lp_mode (0 = hibernate, register at address 3; 1 = sleep, register at address 4). In that bit, 0 means in reset and 1 means free.
- R9: While lp_valid is 0, the lines follow their run-mode state and the override registers have no effect.
- R10: Reading address 0 returns the present level of each line: 1 = free, 0 = in reset. Reads of addresses 3 and 4 return the override registers. Writes to addresses above 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | NUM_LINES | Write line mask or override value |
| rd_addr | input | 3 | Read register address |
| rd_data | output | NUM_LINES | Read data (combinational) |
| lp_valid | input | 1 | Low-power request valid |
| lp_mode | input | 1 | Low-power state: 0 hibernate, 1 sleep |
| rst_n_o | output | NUM_LINES | Active-low reset lines |

## Verification
A table of mixed mask writes covers several cases:

- **Partial masks:** these show that each line keeps its own state and that lines outside the mask are untouched.
- **Overrides:** differing patterns are loaded into the two override registers and both low-power states are then selected. This separates the hibernate path from the sleep path and from the run path.
- **Pulses:** the pulse is timed edge by edge, to tell exact-length behaviour from an off-by-one. Further pulse tests start from a freed line, from a held line, and interrupted by free or hold, which tells restart from cancel.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_HOLD   = 3'd0,
        A_FREE   = 3'd1,
        A_PULSE  = 3'd2,
        A_HIB    = 3'd3,
        A_SLEEP  = 3'd4
    } reg_addr_e;

    typedef enum logic {
        LP_HIB   = 1'b0,
        LP_SLEEP = 1'b1
    } lp_mode_e;

    typedef struct packed {
        logic hold;
        logic free;
        logic pulse;
    } line_cmd_t;

    function automatic int cnt_width(input int cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/rlc_regdec.sv
module rlc_regdec
    import rlc_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [NUM_LINES-1:0]       wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NUM_LINES-1:0]       level_i,
    input  logic [NUM_LINES-1:0]       busy_i,
    output line_cmd_t [NUM_LINES-1:0]  cmd_o,
    output logic [NUM_LINES-1:0]       hib_cfg_o,
    output logic [NUM_LINES-1:0]       sleep_cfg_o,
    output logic [NUM_LINES-1:0]       rd_data
);

    logic [NUM_LINES-1:0] hib_q, sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hib_q   <= '0;
            sleep_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_HIB)   hib_q   <= wr_data;
            if (wr_addr == A_SLEEP) sleep_q <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmd
        always_comb begin
            cmd_o[i].hold  = wr_en && (wr_addr == A_HOLD)  && wr_data[i];
            cmd_o[i].free  = wr_en && (wr_addr == A_FREE)  && wr_data[i];
            cmd_o[i].pulse = wr_en && (wr_addr == A_PULSE) && wr_data[i];
        end
    end

    always_comb begin
        case (rd_addr)
            A_HOLD:  rd_data = level_i;
            A_FREE:  rd_data = busy_i;
            A_HIB:   rd_data = hib_q;
            A_SLEEP: rd_data = sleep_q;
            default: rd_data = '0;
        endcase
    end

    assign hib_cfg_o   = hib_q;
    assign sleep_cfg_o = sleep_q;

endmodule

// File: rtl/rlc_line.sv
module rlc_line
    import rlc_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  line_cmd_t cmd_i,
    output logic      asserted_o,
    output logic      busy_o
);

    localparam int CNT_W = cnt_width(PULSE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             asserted_q, busy_q;

    // Priority: free, then pulse, then hold, then timer.
    always_ff @(posedge clk) begin
        if (rst) begin
            asserted_q <= 1'b1;
            busy_q     <= 1'b0;
            cnt_q      <= '0;
        end else if (cmd_i.free) begin
            asserted_q <= 1'b0;
            busy_q     <= 1'b0;
        end else if (cmd_i.pulse) begin
            asserted_q <= 1'b1;
            busy_q     <= 1'b1;
            cnt_q      <= '0;
        end else if (cmd_i.hold) begin
            asserted_q <= 1'b1;
            busy_q     <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                asserted_q <= 1'b0;
                busy_q     <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign asserted_o = asserted_q;
    assign busy_o     = busy_q;

endmodule

// File: rtl/rlc_lpmux.sv
module rlc_lpmux
    import rlc_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_LINES-1:0] run_assert_i,
    input  logic [NUM_LINES-1:0] hib_cfg_i,
    input  logic [NUM_LINES-1:0] sleep_cfg_i,
    input  logic                 lp_valid,
    input  lp_mode_e             lp_mode,
    output logic [NUM_LINES-1:0] rst_n_o
);

    always_comb begin
        if (!lp_valid)               rst_n_o = ~run_assert_i;
        else if (lp_mode == LP_HIB)  rst_n_o = hib_cfg_i;
        else                         rst_n_o = sleep_cfg_i;
    end

endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
    import rlc_pkg::*;
#(
    parameter int NUM_LINES    = 4,
    parameter int PULSE_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [2:0]             wr_addr,
    input  logic [NUM_LINES-1:0]   wr_data,
    input  logic [2:0]             rd_addr,
    output logic [NUM_LINES-1:0]   rd_data,
    input  logic                   lp_valid,
    input  logic                   lp_mode,
    output logic [NUM_LINES-1:0]   rst_n_o
);

    line_cmd_t [NUM_LINES-1:0] cmd;
    logic [NUM_LINES-1:0]      assert_vec, busy_vec, hib_cfg, sleep_cfg;

    rlc_regdec #(.NUM_LINES(NUM_LINES)) u_regdec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .level_i     (rst_n_o),
        .busy_i      (busy_vec),
        .cmd_o       (cmd),
        .hib_cfg_o   (hib_cfg),
        .sleep_cfg_o (sleep_cfg),
        .rd_data     (rd_data)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        rlc_line #(.PULSE_CYCLES(PULSE_CYCLES)) u_line (
            .clk        (clk),
            .rst        (rst),
            .cmd_i      (cmd[i]),
            .asserted_o (assert_vec[i]),
            .busy_o     (busy_vec[i])
        );
    end

    rlc_lpmux #(.NUM_LINES(NUM_LINES)) u_lpmux (
        .run_assert_i (assert_vec),
        .hib_cfg_i    (hib_cfg),
        .sleep_cfg_i  (sleep_cfg),
        .lp_valid     (lp_valid),
        .lp_mode      (lp_mode_e'(lp_mode)),
        .rst_n_o      (rst_n_o)
    );

endmodule

// File: rtl/rst_line_ctrl_chk.sv
module rst_line_ctrl_chk #(
    parameter int NUM_LINES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [2:0]           wr_addr,
    input logic [NUM_LINES-1:0] wr_data,
    input logic                 lp_valid,
    input logic [NUM_LINES-1:0] rst_n_o,
    input logic [NUM_LINES-1:0] assert_vec,
    input logic [NUM_LINES-1:0] busy_vec
);

    // R1: lines in reset and no timer busy on the cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (rst_n_o == '0) && (busy_vec == '0));

    // R2: masked lines are in reset after a hold write
    a_r2_hold_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> ((~assert_vec & $past(wr_data)) == '0));

    // R2: with no write and no timer, run state never changes
    a_r2_no_timeout: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && busy_vec == '0) |=> $stable(assert_vec));

    // R3: masked lines are free after a free write
    a_r3_free_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> ((assert_vec & $past(wr_data)) == '0));

    // R5: a busy line is always held in reset
    a_r5_busy_implies_held: assert property (@(posedge clk) disable iff (rst)
        (busy_vec & ~assert_vec) == '0);

    // R9: outside low power the lines follow run state
    a_r9_run_path: assert property (@(posedge clk) disable iff (rst)
        !lp_valid |-> (rst_n_o == ~assert_vec));

endmodule

bind rst_line_ctrl rst_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lp_valid   (lp_valid),
    .rst_n_o    (rst_n_o),
    .assert_vec (assert_vec),
    .busy_vec   (busy_vec)
);

// File: tb/rst_line_ctrl_test.sv
module rst_line_ctrl_test;

    localparam int N  = 4;
    localparam int PC = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         lp_valid = 1'b0;
    logic         lp_mode = 1'b0;
    logic [N-1:0] rst_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rst_line_ctrl #(.NUM_LINES(N), .PULSE_CYCLES(PC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lp_valid(lp_valid), .lp_mode(lp_mode), .rst_n_o(rst_n_o)
    );

    // {wr, addr[2:0], data[3:0], lp_valid, lp_mode, exp_rst_n[3:0]}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 3'd1, 4'b1111, 1'b0, 1'b0, 4'b1111}, // R3 free all
        {1'b1, 3'd0, 4'b0101, 1'b0, 1'b0, 4'b1010}, // R2 hold mask
        {1'b0, 3'd0, 4'b0000, 1'b0, 1'b0, 4'b1010}, // R2 held
        {1'b1, 3'd1, 4'b0001, 1'b0, 1'b0, 4'b1011}, // R3 partial free
        {1'b1, 3'd3, 4'b0110, 1'b0, 1'b0, 4'b1011}, // R9 hib cfg inactive
        {1'b1, 3'd4, 4'b1001, 1'b0, 1'b0, 4'b1011}, // R9 sleep cfg inactive
        {1'b0, 3'd0, 4'b0000, 1'b1, 1'b0, 4'b0110}, // R8 hibernate
        {1'b0, 3'd0, 4'b0000, 1'b1, 1'b1, 4'b1001}, // R8 sleep
        {1'b0, 3'd0, 4'b0000, 1'b0, 1'b0, 4'b1011}, // R9 back to run
        {1'b1, 3'd6, 4'b1111, 1'b0, 1'b0, 4'b1011}, // R10 unmapped write
        {1'b1, 3'd1, 4'b1111, 1'b0, 1'b0, 4'b1111}, // R3 free all
        {1'b1, 3'd0, 4'b1111, 1'b0, 1'b0, 4'b0000}  // R2 hold all
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [N-1:0] r;
        wait_cyc(3);
        // R1 during reset
        check("R1 lines", rst_n_o, 4'b0000);
        rd(3'd1, r); check("R1 busy", r, 4'b0000);
        rd(3'd3, r); check("R1 hib cfg", r, 4'b0000);
        rd(3'd4, r); check("R1 sleep cfg", r, 4'b0000);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 after reset", rst_n_o, 4'b0000);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en    = VEC[v][13];
            wr_addr  = VEC[v][12:10];
            wr_data  = VEC[v][9:6];
            lp_valid = VEC[v][5];
            lp_mode  = VEC[v][4];
            @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("R10 vec%0d level", v), rst_n_o, VEC[v][3:0]);
            rd(3'd0, r);
            check($sformatf("R10 vec%0d status", v), r, VEC[v][3:0]);
        end
        lp_valid = 1'b0;
        rd(3'd3, r); check("R10 hib readback", r, 4'b0110);
        rd(3'd4, r); check("R10 sleep readback", r, 4'b1001);

        // R2 no timeout
        wait_cyc(100);
        check("R2 no timeout", rst_n_o, 4'b0000);

        // R4/R5 pulse on a freed line
        wr(3'd1, 4'b1111);
        wr(3'd2, 4'b0001);
        check("R4 pulse start", rst_n_o, 4'b1110);
        rd(3'd1, r); check("R5 busy set", r, 4'b0001);
        wait_cyc(PC - 1);
        check("R4 pulse last low cycle", rst_n_o, 4'b1110);
        wait_cyc(1);
        check("R4 pulse released", rst_n_o, 4'b1111);
        rd(3'd1, r); check("R5 busy clear", r, 4'b0000);

        // R6 pulse on held line restarts
        wr(3'd0, 4'b0010);
        wait_cyc(5);
        wr(3'd2, 4'b0010);
        wait_cyc(PC - 1);
        check("R6 held through restart", rst_n_o, 4'b1101);
        wait_cyc(1);
        check("R6 released after restart", rst_n_o, 4'b1111);

        // R6 pulse during pulse restarts timer
        wr(3'd2, 4'b0010);
        wait_cyc(6);
        wr(3'd2, 4'b0010);
        wait_cyc(PC - 1);
        check("R6 repulse still low", rst_n_o, 4'b1101);
        wait_cyc(1);
        check("R6 repulse released", rst_n_o, 4'b1111);

        // R7 free during pulse
        wr(3'd2, 4'b0100);
        wait_cyc(3);
        wr(3'd1, 4'b0100);
        check("R7 free cancels pulse", rst_n_o, 4'b1111);
        rd(3'd1, r); check("R7 busy cleared by free", r, 4'b0000);

        // R7 hold during pulse
        wr(3'd2, 4'b1000);
        wait_cyc(3);
        wr(3'd0, 4'b1000);
        rd(3'd1, r); check("R7 busy cleared by hold", r, 4'b0000);
        wait_cyc(3 * PC);
        check("R7 hold persists", rst_n_o, 4'b0111);

        // R8 override during a pulse, then run path resumes
        wr(3'd1, 4'b1111);
        wr(3'd2, 4'b0001);
        lp_valid = 1'b1; lp_mode = 1'b1;
        #1;
        check("R8 sleep override in pulse", rst_n_o, 4'b1001);
        lp_valid = 1'b0;
        #1;
        check("R9 run path in pulse", rst_n_o, 4'b1110);

        // R1 reset mid-operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset re-asserts", rst_n_o, 4'b0000);
        rd(3'd1, r); check("R1 busy after reset", r, 4'b0000);
        rd(3'd4, r); check("R1 sleep cfg after reset", r, 4'b0000);

        done = 1'b1;
        summary();
    end

endmodule